// File: doc/BRIEF.md
# Trigger-Windowed Hit Time Capture

This block time-stamps hits on a bank of channels against an external trigger. Each trigger opens a window of numbered slots, one per main-clock cycle (one slot equals 25 ns at the intended clock rate). A bit mask picks which slots may accept hits. When a channel sees its first hit in an enabled slot, it stores the slot index together with a fine-time code. That code is captured on the trigger edge from the measurement logic that sits in front of this block. Each channel has its own queue, and the queues are read back independently.

Software or a sequencer drives a one-cycle reset pulse. It can also hold a busy flag high, for example during calibration, to keep the block from capturing. A per-channel disable mask silences noisy or unused channels. The trigger enters already synchronized to the main clock, and every control and status pin is synchronous to that clock.

Each queue is a valid/ready stream. A word is taken only on a cycle where valid and ready are both high. While ready is low, valid stays high and the word on the data lines does not change. A queue never stalls capture: when it is full, the new word is dropped and that channel's overflow flag is raised.

Top module: `tdc_window_capture`

## Requirements
- R1: A reset pulse on `rst_i` in cycle R drives `resetting_o` high for exactly `RST_LEN` cycles, R+1 through R+`RST_LEN`. From cycle R+1 onward, every queue is empty and every overflow flag is clear.
- R2: The cycle in which `trig_i` is high after having been low is the edge cycle E. Slot n is cycle E+1+n, for n from 0 to `NUM_SLOTS`-1. A hit captured in slot n stores n as its slot index.
- R3: A hit is recorded only while the window is open and bit n of `win_mask_i` is set. Hits in slots whose mask bit is clear, hits with no trigger, and hits from cycle E+1+`NUM_SLOTS` onward leave every queue empty.
- R4: A channel whose bit is set in `chan_mask_i` never records a hit.
- R5: Each channel records at most one hit per trigger, namely the first one accepted. Later hits in the same window are ignored.
- R6: A stored word is {slot index in bits [13:9], fine code in bits [8:0]}. The fine code is the value on `fine_i` in the edge cycle. Channel c's word sits at `evt_data_o[c*14 +: 14]`.
- R7: While `busy_i` is high, no hit is recorded.
- R8: The queues are first-in first-out. A word is removed only in a cycle where valid and ready are both high. While ready is low, valid and data hold.
- R9: A hit that meets a full queue is dropped and sets that channel's overflow flag, even if the same cycle also pops a word. The flag stays set until the next reset. If a queue that is not full gets a push and a pop in the same cycle, it keeps both words' effects.
- R10: A new trigger edge inside an open window restarts the window at slot 0 and lets every channel record again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_i | input | 1 | One-cycle synchronous reset pulse |
| busy_i | input | 1 | High while capture must be held off, such as during calibration |
| trig_i | input | 1 | Synchronized trigger level; its rising edge opens a window |
| fine_i | input | FINE_W | Fine-time code, sampled in the edge cycle |
| hit_i | input | NUM_CH | Per-channel hit lines |
| chan_mask_i | input | NUM_CH | Per-channel disable, 1 = disabled |
| win_mask_i | input | NUM_SLOTS | Slot enable, bit n = slot n |
| evt_valid_o | output | NUM_CH | Per-queue word available |
| evt_ready_i | input | NUM_CH | Per-queue pop request |
| evt_data_o | output | NUM_CH*(SLOT_W+FINE_W) | Head word of every queue, concatenated |
| overflow_o | output | NUM_CH | Sticky per-channel drop flag |
| resetting_o | output | 1 | High while the reset sequence runs |

## Verification
A capture push and a reader pop can land on the same queue in the same cycle. The bench forces this by raising ready in the same cycle as the hit. It does this once with a full queue, where the result must be one word popped, the new word dropped, and the overflow flag set. It does it again with a queue holding three words, where the result must be both effects, seen in the order of the words read out next. Exhaustive sweeps over all 32 slots under a fixed window pattern and a fixed channel mask check slot indexing, masking and word format arithmetically.

// File: rtl/tdc_cap_pkg.sv
package tdc_cap_pkg;
  // Per-trigger state of one channel
  typedef enum logic {
    CH_ARMED = 1'b0,
    CH_TAKEN = 1'b1
  } ch_state_e;

  localparam int unsigned DEF_NUM_CH    = 24;
  localparam int unsigned DEF_NUM_SLOTS = 32;
  localparam int unsigned DEF_FINE_W    = 9;
  localparam int unsigned DEF_DEPTH     = 4;
  localparam int unsigned DEF_RST_LEN   = 4;
endpackage

// File: rtl/tdc_reset_seq.sv
module tdc_reset_seq #(
  parameter int unsigned RST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic resetting_o
);
  localparam int unsigned CNT_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)
      remain_q <= CNT_W'(RST_LEN);
    else if (remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign resetting_o = (remain_q != '0);
endmodule

// File: rtl/tdc_trig_window.sv
module tdc_trig_window #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned FINE_W    = 9,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              clear_i,
  input  logic              trig_i,
  input  logic [FINE_W-1:0] fine_i,
  output logic              rearm_o,
  output logic              open_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [FINE_W-1:0] fine_o
);
  logic              trig_q;
  logic              open_q;
  logic [SLOT_W-1:0] slot_q;
  logic [FINE_W-1:0] fine_q;
  logic              edge_w;

  assign edge_w = trig_i & ~trig_q;

  always_ff @(posedge clk_i) begin
    if (clear_i) begin
      trig_q <= 1'b0;
      open_q <= 1'b0;
      slot_q <= '0;
      fine_q <= '0;
    end else begin
      trig_q <= trig_i;
      if (edge_w) begin
        open_q <= 1'b1;
        slot_q <= '0;
        fine_q <= fine_i;
      end else if (open_q) begin
        if (slot_q == SLOT_W'(NUM_SLOTS - 1))
          open_q <= 1'b0;
        else
          slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign rearm_o = edge_w & ~clear_i;
  assign open_o  = open_q;
  assign slot_o  = slot_q;
  assign fine_o  = fine_q;
endmodule

// File: rtl/tdc_chan_capture.sv
module tdc_chan_capture
  import tdc_cap_pkg::*;
(
  input  logic clk_i,
  input  logic clear_i,
  input  logic rearm_i,
  input  logic slot_ok_i,
  input  logic hit_i,
  input  logic disable_i,
  input  logic full_i,
  output logic push_o,
  output logic overflow_o
);
  ch_state_e state_q;
  logic      ovf_q;
  logic      accept_w;

  assign accept_w = slot_ok_i & hit_i & ~disable_i & (state_q == CH_ARMED) & ~clear_i;

  always_ff @(posedge clk_i) begin
    if (clear_i) begin
      state_q <= CH_ARMED;
      ovf_q   <= 1'b0;
    end else begin
      if (rearm_i)
        state_q <= CH_ARMED;
      else if (accept_w)
        state_q <= CH_TAKEN;
      if (accept_w && full_i)
        ovf_q <= 1'b1;
    end
  end

  assign push_o     = accept_w & ~full_i;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/tdc_evt_fifo.sv
module tdc_evt_fifo #(
  parameter int unsigned W     = 14,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         clear_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] dout_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = valid_o & ready_i;
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push && !clear_i)
      mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i) begin
    if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= next_ptr(wr_q);
      if (do_pop)  rd_q <= next_ptr(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tdc_window_capture.sv
module tdc_window_capture
  import tdc_cap_pkg::*;
#(
  parameter int unsigned NUM_CH    = DEF_NUM_CH,
  parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
  parameter int unsigned FINE_W    = DEF_FINE_W,
  parameter int unsigned DEPTH     = DEF_DEPTH,
  parameter int unsigned RST_LEN   = DEF_RST_LEN,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned WORD_W   = SLOT_W + FINE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     busy_i,
  input  logic                     trig_i,
  input  logic [FINE_W-1:0]        fine_i,
  input  logic [NUM_CH-1:0]        hit_i,
  input  logic [NUM_CH-1:0]        chan_mask_i,
  input  logic [NUM_SLOTS-1:0]     win_mask_i,
  output logic [NUM_CH-1:0]        evt_valid_o,
  input  logic [NUM_CH-1:0]        evt_ready_i,
  output logic [NUM_CH*WORD_W-1:0] evt_data_o,
  output logic [NUM_CH-1:0]        overflow_o,
  output logic                     resetting_o
);
  logic              clear_w;
  logic              rearm_w;
  logic              open_w;
  logic [SLOT_W-1:0] slot_w;
  logic [FINE_W-1:0] fine_w;
  logic              slot_ok_w;
  logic [WORD_W-1:0] word_w;
  logic [NUM_CH-1:0] push_w;
  logic [NUM_CH-1:0] full_w;

  tdc_reset_seq #(.RST_LEN(RST_LEN)) u_rst (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .resetting_o (resetting_o)
  );

  assign clear_w = rst_i | resetting_o;

  tdc_trig_window #(.NUM_SLOTS(NUM_SLOTS), .FINE_W(FINE_W)) u_win (
    .clk_i   (clk_i),
    .clear_i (clear_w),
    .trig_i  (trig_i),
    .fine_i  (fine_i),
    .rearm_o (rearm_w),
    .open_o  (open_w),
    .slot_o  (slot_w),
    .fine_o  (fine_w)
  );

  // A slot accepts hits only when the block is active and the slot is enabled
  assign slot_ok_w = open_w & win_mask_i[slot_w] & ~busy_i;
  assign word_w    = {slot_w, fine_w};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tdc_chan_capture u_cap (
      .clk_i      (clk_i),
      .clear_i    (clear_w),
      .rearm_i    (rearm_w),
      .slot_ok_i  (slot_ok_w),
      .hit_i      (hit_i[c]),
      .disable_i  (chan_mask_i[c]),
      .full_i     (full_w[c]),
      .push_o     (push_w[c]),
      .overflow_o (overflow_o[c])
    );

    tdc_evt_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .clear_i (clear_w),
      .push_i  (push_w[c]),
      .din_i   (word_w),
      .full_o  (full_w[c]),
      .valid_o (evt_valid_o[c]),
      .ready_i (evt_ready_i[c]),
      .dout_o  (evt_data_o[c*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/tdc_window_capture_chk.sv
module tdc_window_capture_chk #(
  parameter int unsigned NUM_CH    = 24,
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 busy_i,
  input logic                 resetting_i,
  input logic [NUM_CH-1:0]    chan_mask_i,
  input logic [NUM_SLOTS-1:0] win_mask_i,
  input logic [NUM_CH-1:0]    evt_valid_i,
  input logic [NUM_CH-1:0]    evt_ready_i,
  input logic [NUM_CH-1:0]    overflow_i,
  input logic [NUM_CH-1:0]    push_i,
  input logic                 open_i,
  input logic [SLOT_W-1:0]    slot_i
);
  a_r1_clear_in_reset: assert property (@(posedge clk_i) disable iff (rst_i)
    resetting_i |-> (evt_valid_i == '0 && overflow_i == '0));

  a_r3_push_in_open_slot: assert property (@(posedge clk_i) disable iff (rst_i || resetting_i)
    (push_i != '0) |-> (open_i && win_mask_i[slot_i]));

  a_r4_masked_silent: assert property (@(posedge clk_i) disable iff (rst_i || resetting_i)
    (push_i & chan_mask_i) == '0);

  a_r7_busy_holds_off: assert property (@(posedge clk_i) disable iff (rst_i || resetting_i)
    busy_i |-> (push_i == '0));

  a_r8_valid_held: assert property (@(posedge clk_i) disable iff (rst_i || resetting_i)
    ((evt_valid_i & ~evt_ready_i) != '0) |=>
      (($past(evt_valid_i & ~evt_ready_i) & ~evt_valid_i) == '0));

  a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (overflow_i != '0) |=> ((overflow_i & $past(overflow_i)) == $past(overflow_i)));
endmodule

bind tdc_window_capture tdc_window_capture_chk #(
  .NUM_CH    (NUM_CH),
  .NUM_SLOTS (NUM_SLOTS)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .busy_i      (busy_i),
  .resetting_i (resetting_o),
  .chan_mask_i (chan_mask_i),
  .win_mask_i  (win_mask_i),
  .evt_valid_i (evt_valid_o),
  .evt_ready_i (evt_ready_i),
  .overflow_i  (overflow_o),
  .push_i      (push_w),
  .open_i      (open_w),
  .slot_i      (slot_w)
);

// File: tb/test_tdc_window_capture.sv
module test_tdc_window_capture;
  localparam int NCH = 24;
  localparam int NSL = 32;
  localparam int FW  = 9;
  localparam int DEP = 4;
  localparam int RL  = 4;
  localparam int WW  = 14;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           busy = 1'b0;
  logic           trig = 1'b0;
  logic [FW-1:0]  fine = '0;
  logic [NCH-1:0] hit = '0;
  logic [NCH-1:0] cmask = '0;
  logic [NSL-1:0] wmask = '1;
  logic [NCH-1:0] valid;
  logic [NCH-1:0] ready = '0;
  logic [NCH*WW-1:0] data;
  logic [NCH-1:0] ovf;
  logic           resetting;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tdc_window_capture #(.NUM_CH(NCH), .NUM_SLOTS(NSL), .FINE_W(FW), .DEPTH(DEP), .RST_LEN(RL))
  i_tdc_window_capture (
    .clk_i(clk), .rst_i(rst), .busy_i(busy), .trig_i(trig), .fine_i(fine),
    .hit_i(hit), .chan_mask_i(cmask), .win_mask_i(wmask),
    .evt_valid_o(valid), .evt_ready_i(ready), .evt_data_o(data),
    .overflow_o(ovf), .resetting_o(resetting)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick; @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] word_of(input int c);
    return data[c*WW +: WW];
  endfunction

  function automatic logic [WW-1:0] expw(input int slot, input int f);
    return WW'((slot << FW) | (f & ((1 << FW) - 1)));
  endfunction

  task automatic do_reset;
    rst = 1'b1; tick; rst = 1'b0;
  endtask

  // Edge cycle, then returns at the start of slot 0
  task automatic fire(input int f);
    trig = 1'b1; fine = FW'(f); tick;
    trig = 1'b0; fine = '0;
  endtask

  // From the start of slot k0, wait to slot n, hit, return at the start of n+1
  task automatic hit_at(input int n, input logic [NCH-1:0] v, input logic [NCH-1:0] rdy);
    repeat (n) tick;
    hit = v; ready = rdy; tick;
    hit = '0; ready = '0;
  endtask

  task automatic close_window; repeat (NSL + 2) tick; endtask

  task automatic pop_chk(input int c, input logic [WW-1:0] e, input string req);
    check(valid[c] === 1'b1, req, valid[c], 1);
    check(word_of(c) === e, req, word_of(c), e);
    ready[c] = 1'b1; tick; ready[c] = 1'b0;
  endtask

  initial begin
    logic [NCH-1:0] evec;
    int n_rst;
    tick; tick;
    do_reset;
    // R1: resetting window length and cleared state
    n_rst = 0;
    while (resetting === 1'b1 && n_rst < 20) begin
      check(valid === '0 && ovf === '0, "R1 clear during reset", valid, 0);
      n_rst++; tick;
    end
    check(n_rst == RL, "R1 resetting length", n_rst, RL);
    check(valid === '0, "R1 empty after reset", valid, 0);

    // R2 R6: every slot, one channel per slot
    for (int n = 0; n < NSL; n++) begin
      int c = n % NCH;
      int f = (n * 37 + 5) % 512;
      fire(f);
      hit_at(n, NCH'(1) << c, '0);
      close_window;
      check(valid === (NCH'(1) << c), "R2 only hit channel valid", valid, NCH'(1) << c);
      pop_chk(c, expw(n, f), "R6 word slot and fine");
    end

    // R3 R4: window pattern and channel mask swept over all slots
    wmask = 32'hA5A5_3C3C;
    cmask = 24'h00F0F1;
    for (int n = 0; n < NSL; n++) begin
      fire(n + 100);
      hit_at(n, '1, '0);
      close_window;
      evec = wmask[n] ? ~cmask : '0;
      check(valid === evec, wmask[n] ? "R4 masked channels silent" : "R3 disabled slot ignored",
            valid, evec);
      for (int c = 0; c < NCH; c++)
        if (evec[c]) pop_chk(c, expw(n, n + 100), "R3 enabled slot word");
    end
    wmask = '1; cmask = '0;

    // R3: no trigger, and one cycle past the last slot
    hit = '1; tick; hit = '0; tick;
    check(valid === '0, "R3 hit without trigger", valid, 0);
    fire(7);
    hit_at(NSL, '1, '0);
    tick;
    check(valid === '0, "R3 hit after window", valid, 0);

    // R5: first hit only
    fire(33);
    hit_at(3, NCH'(1) << 5, '0);
    hit_at(3, NCH'(1) << 5, '0);
    close_window;
    pop_chk(5, expw(3, 33), "R5 first hit kept");
    check(valid === '0, "R5 second hit ignored", valid, 0);

    // R10: retrigger inside window
    fire(200);
    hit_at(2, 24'h1, '0);
    tick; tick;
    fire(300);
    hit_at(4, 24'h1, '0);
    close_window;
    pop_chk(0, expw(2, 200), "R10 first window word");
    pop_chk(0, expw(4, 300), "R10 rearmed word");
    check(valid === '0, "R10 no extra word", valid, 0);

    // R7: busy blocks capture
    busy = 1'b1;
    fire(9);
    hit_at(0, '1, '0);
    close_window;
    check(valid === '0, "R7 busy no capture", valid, 0);
    busy = 1'b0;

    // R8: hold under back-pressure
    fire(77);
    hit_at(6, NCH'(1) << 9, '0);
    close_window;
    for (int k = 0; k < 5; k++) begin
      check(valid[9] === 1'b1, "R8 valid held", valid[9], 1);
      check(word_of(9) === expw(6, 77), "R8 data held", word_of(9), expw(6, 77));
      tick;
    end
    pop_chk(9, expw(6, 77), "R8 pop");
    check(valid[9] === 1'b0, "R8 empty after pop", valid[9], 0);

    // R9: overflow on fifth word, order kept, sticky
    for (int k = 1; k <= DEP + 1; k++) begin
      fire(k);
      hit_at(k, NCH'(1) << 2, '0);
      close_window;
    end
    check(ovf === (NCH'(1) << 2), "R9 overflow set", ovf, NCH'(1) << 2);
    for (int k = 1; k <= DEP; k++) pop_chk(2, expw(k, k), "R8 fifo order");
    check(valid[2] === 1'b0, "R9 dropped word absent", valid[2], 0);
    tick; tick;
    check(ovf === (NCH'(1) << 2), "R9 overflow sticky", ovf, NCH'(1) << 2);
    do_reset;
    repeat (RL) tick;
    check(ovf === '0, "R1 reset clears overflow", ovf, 0);

    // R9: full queue with pop in the hit cycle drops the new word
    for (int k = 10; k < 10 + DEP; k++) begin
      fire(k);
      hit_at(k, NCH'(1) << 2, '0);
      close_window;
    end
    fire(14);
    hit_at(14, NCH'(1) << 2, NCH'(1) << 2);
    close_window;
    check(ovf[2] === 1'b1, "R9 full plus pop still overflows", ovf[2], 1);
    // R9: push and pop together on a non-full queue
    fire(20);
    hit_at(20, NCH'(1) << 2, NCH'(1) << 2);
    close_window;
    pop_chk(2, expw(12, 12), "R9 order after joint cycle");
    pop_chk(2, expw(13, 13), "R9 order after joint cycle");
    pop_chk(2, expw(20, 20), "R9 joint push stored");
    check(valid[2] === 1'b0, "R9 queue drained", valid[2], 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule